// File: doc/BRIEF.md
# Maximal-Length Fibonacci LFSR

This block is a Fibonacci linear-feedback shift register whose length is set by a parameter to any value from 3 to 7 stages. Each clock in which it is allowed to advance, it forms a feedback bit as the XOR of two fixed stages and feeds that bit into stage 1. Every other stage takes the value of its neighbour on the input side. Stage 1 is the input end and stage N is the output end. The tap pair for each length is chosen from a fixed table, so the register runs through every nonzero state before it repeats.

The register can be seeded with any value through a synchronous load. It leaves the all-zero lock-up state by itself on the next clock. The whole state is visible in parallel, with stage 1 in the most significant bit, and the last stage is also presented as a serial bit. Typical uses are test-pattern generation, scrambling and cheap pseudo-random sequencing.

Top module: `lfsr_max`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, `pattern` holds 0…01: only the last stage (bit 0) is set.
- R2: Stage k (1 = input end) sits at `pattern` bit N−k. The feedback bits are fixed per length. N=3 uses stages 3 and 2. N=4 uses 4 and 3. N=5 uses 5 and 3. N=6 uses 6 and 5. N=7 uses 7 and 6. On an advance the new bit N−1 is the XOR of the two tap stages, and bits N−2..0 take the old bits N−1..1.
- R3: For N=4, starting from 0001, successive advances give 1000, 0100, 0010, 1001, 1100, 0110, 1011, 0101, 1010, 1101, 1110, 1111, 0111, 0011, and then 0001 again.
- R4: Starting from 0…01 with `en` held high, the state first returns to 0…01 after exactly 2^N−1 advances: 7, 15, 31, 63 or 127.
- R5: The all-zero state never appears during free running.
- R6: When `load` is high at a clock edge, `pattern` becomes `seed` after that edge, whatever `en` is.
- R7: When `load` and `en` are high together, the load wins and no shift takes place. A zero seed held on `load` keeps the register at zero.
- R8: When `pattern` is all zeros and `load` is low, the next clock sets it to 0…01, whatever `en` is.
- R9: When `load` is low, `en` is low and the state is nonzero, the state is unchanged.
- R10: `ser_out` always equals the last stage, bit 0 of `pattern`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance the register by one step |
| load | input | 1 | Synchronous seed load, highest priority |
| seed | input | WIDTH | Value written by `load` |
| pattern | output | WIDTH | Parallel state, stage 1 in the MSB |
| ser_out | output | 1 | Serial output, the last stage |

## Verification
Three functions can claim the same clock edge: the seed load, the shift enabled by `en`, and the all-zero restart. The bench raises `load` and `en` together with a nonzero seed and expects the seed unshifted one cycle later. It then loads a zero seed for two cycles with `en` high and expects zero to persist. Finally it drops `load` and expects 0…01 on the next cycle even with `en` low. Each case is judged by comparing `pattern` to the value the priority order gives, across several widths at once.

// File: rtl/lfsr_max_pkg.sv
package lfsr_max_pkg;

    // Source of the next register value, in priority order seed > restart > shift > hold
    typedef enum logic [1:0] {
        SRC_HOLD    = 2'd0,
        SRC_SHIFT   = 2'd1,
        SRC_SEED    = 2'd2,
        SRC_RESTART = 2'd3
    } src_e;

    localparam int MIN_WIDTH = 3;
    localparam int MAX_WIDTH = 7;

    // Far tap: always the last stage
    function automatic int far_tap(input int w);
        return w;
    endfunction

    // Near tap: the second feedback stage per length
    function automatic int near_tap(input int w);
        int s;
        case (w)
            5:       s = 3;
            default: s = w - 1;
        endcase
        return s;
    endfunction

    // Stage numbers run from 1 at the input end; stage 1 is the MSB
    function automatic int stage_bit(input int w, input int stage);
        return w - stage;
    endfunction

endpackage

// File: rtl/lfsr_tap_xor.sv
module lfsr_tap_xor
    import lfsr_max_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] sr,
    output logic             fb
);

    localparam int FAR_BIT  = stage_bit(WIDTH, far_tap(WIDTH));
    localparam int NEAR_BIT = stage_bit(WIDTH, near_tap(WIDTH));

    logic [WIDTH-1:0] tap_mask;

    for (genvar i = 0; i < WIDTH; i++) begin : g_mask
        if (i == FAR_BIT || i == NEAR_BIT) begin : g_on
            assign tap_mask[i] = 1'b1;
        end else begin : g_off
            assign tap_mask[i] = 1'b0;
        end
    end

    assign fb = ^(sr & tap_mask);

endmodule

// File: rtl/lfsr_zero_det.sv
module lfsr_zero_det #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] sr,
    output logic             is_zero
);

    assign is_zero = ~|sr;

endmodule

// File: rtl/lfsr_src_sel.sv
module lfsr_src_sel
    import lfsr_max_pkg::*;
(
    input  logic load,
    input  logic en,
    input  logic is_zero,
    output src_e src
);

    always_comb begin
        if (load) begin
            src = SRC_SEED;
        end else if (is_zero) begin
            src = SRC_RESTART;
        end else if (en) begin
            src = SRC_SHIFT;
        end else begin
            src = SRC_HOLD;
        end
    end

endmodule

// File: rtl/lfsr_max.sv
module lfsr_max
    import lfsr_max_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic [WIDTH-1:0] seed,
    output logic [WIDTH-1:0] pattern,
    output logic             ser_out
);

    localparam logic [WIDTH-1:0] RESTART_VAL = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] sr;
    } lfsr_state_t;

    lfsr_state_t r_d, r_q;
    logic        fb;
    logic        is_zero;
    src_e        src;

    lfsr_tap_xor #(.WIDTH(WIDTH)) u_tap_xor (
        .sr (r_q.sr),
        .fb (fb)
    );

    lfsr_zero_det #(.WIDTH(WIDTH)) u_zero_det (
        .sr      (r_q.sr),
        .is_zero (is_zero)
    );

    lfsr_src_sel u_src_sel (
        .load    (load),
        .en      (en),
        .is_zero (is_zero),
        .src     (src)
    );

    always_comb begin
        r_d = r_q;
        case (src)
            SRC_SEED:    r_d.sr = seed;
            SRC_RESTART: r_d.sr = RESTART_VAL;
            SRC_SHIFT:   r_d.sr = {fb, r_q.sr[WIDTH-1:1]};
            default:     r_d.sr = r_q.sr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.sr <= RESTART_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign pattern = r_q.sr;
    assign ser_out = r_q.sr[0];

endmodule

// File: rtl/lfsr_max_chk.sv
module lfsr_max_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             load,
    input logic [WIDTH-1:0] seed,
    input logic [WIDTH-1:0] pattern,
    input logic             ser_out
);

    // R6
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> pattern == $past(seed));

    // R8
    zero_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && pattern == '0) |=> pattern == WIDTH'(1));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !en && pattern != '0) |=> $stable(pattern));

    // R2
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && en && pattern != '0) |=> pattern[WIDTH-2:0] == $past(pattern[WIDTH-1:1]));

    // R5
    never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && seed == '0) |=> pattern != '0);

    // R10
    serial_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_out == pattern[0]);

endmodule

bind lfsr_max lfsr_max_chk #(.WIDTH(WIDTH)) u_lfsr_max_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .load    (load),
    .seed    (seed),
    .pattern (pattern),
    .ser_out (ser_out)
);

// File: tb/test_lfsr_max.sv
module test_lfsr_max;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       load = 1'b0;
    logic [6:0] seed7 = '0;

    logic [2:0] p3;
    logic [3:0] p4;
    logic [4:0] p5;
    logic [5:0] p6;
    logic [6:0] p7;
    logic       s3, s4, s5, s6, s7;
    logic [6:0] st [3:7];

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lfsr_max #(.WIDTH(3)) i_lfsr_max_w3 (.clk(clk), .rst_n(rst_n), .en(en), .load(load),
        .seed(seed7[2:0]), .pattern(p3), .ser_out(s3));
    lfsr_max #(.WIDTH(4)) i_lfsr_max (.clk(clk), .rst_n(rst_n), .en(en), .load(load),
        .seed(seed7[3:0]), .pattern(p4), .ser_out(s4));
    lfsr_max #(.WIDTH(5)) i_lfsr_max_w5 (.clk(clk), .rst_n(rst_n), .en(en), .load(load),
        .seed(seed7[4:0]), .pattern(p5), .ser_out(s5));
    lfsr_max #(.WIDTH(6)) i_lfsr_max_w6 (.clk(clk), .rst_n(rst_n), .en(en), .load(load),
        .seed(seed7[5:0]), .pattern(p6), .ser_out(s6));
    lfsr_max #(.WIDTH(7)) i_lfsr_max_w7 (.clk(clk), .rst_n(rst_n), .en(en), .load(load),
        .seed(seed7[6:0]), .pattern(p7), .ser_out(s7));

    assign st[3] = {4'b0, p3};
    assign st[4] = {3'b0, p4};
    assign st[5] = {2'b0, p5};
    assign st[6] = {1'b0, p6};
    assign st[7] = p7;

    task automatic chk(input string req, input string what, input logic [6:0] act, input logic [6:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        load = 1'b0;
        en = 1'b0;
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    // R1: reset value on every width, serial bit high
    task automatic t_reset();
        do_reset();
        for (int w = 3; w <= 7; w++) chk("R1", $sformatf("reset w%0d", w), st[w], 7'd1);
        chk("R10", "ser_out after reset", {6'b0, s4}, 7'd1);
        tick();
        for (int w = 3; w <= 7; w++) chk("R1", $sformatf("first cycle w%0d", w), st[w], 7'd1);
    endtask

    // R3 and R10: exact 4-stage order, serial bit tracks the last stage
    task automatic t_order4();
        logic [3:0] exp_seq [15] = '{4'h1, 4'h8, 4'h4, 4'h2, 4'h9, 4'hC, 4'h6, 4'hB,
                                     4'h5, 4'hA, 4'hD, 4'hE, 4'hF, 4'h7, 4'h3};
        do_reset();
        en = 1'b1;
        for (int k = 0; k <= 15; k++) begin
            chk("R3", $sformatf("step %0d", k), {3'b0, p4}, {3'b0, exp_seq[k % 15]});
            chk("R10", $sformatf("serial step %0d", k), {6'b0, s4}, {6'b0, exp_seq[k % 15][0]});
            tick();
        end
        en = 1'b0;
    endtask

    // R4 and R5: period of every width, no zero visited
    task automatic t_period();
        int  per [3:7];
        bit  saw_zero [3:7];
        do_reset();
        for (int w = 3; w <= 7; w++) begin
            per[w] = 0;
            saw_zero[w] = 0;
        end
        en = 1'b1;
        for (int c = 1; c <= 130; c++) begin
            tick();
            for (int w = 3; w <= 7; w++) begin
                if (st[w] == 7'd0) saw_zero[w] = 1;
                if (per[w] == 0 && st[w] == 7'd1) per[w] = c;
            end
        end
        en = 1'b0;
        for (int w = 3; w <= 7; w++) begin
            chk("R4", $sformatf("period w%0d", w), 7'(per[w]), 7'((1 << w) - 1));
            chk("R5", $sformatf("zero seen w%0d", w), {6'b0, saw_zero[w]}, 7'd0);
        end
    endtask

    // R2: one hand-computed shift per length from a chosen state
    task automatic t_taps();
        do_reset();
        seed7 = 7'b1010110;
        load = 1'b1;
        tick();
        load = 1'b0;
        en = 1'b1;
        tick();
        en = 1'b0;
        // w3 110: taps bits0,1 -> 1^0=1 -> 111
        chk("R2", "tap w3", st[3], 7'b0000111);
        // w4 0110: bits0,1 -> 0^1=1 -> 1011
        chk("R2", "tap w4", st[4], 7'b0001011);
        // w5 10110: bits0,2 -> 0^1=1 -> 11011
        chk("R2", "tap w5", st[5], 7'b0011011);
        // w6 010110: bits0,1 -> 0^1=1 -> 101011
        chk("R2", "tap w6", st[6], 7'b0101011);
        // w7 1010110: bits0,1 -> 0^1=1 -> 1101011
        chk("R2", "tap w7", st[7], 7'b1101011);
    endtask

    // R6, R9: load with enable low, then idle hold
    task automatic t_load_hold();
        do_reset();
        seed7 = 7'b0001011;
        en = 1'b0;
        load = 1'b1;
        tick();
        load = 1'b0;
        chk("R6", "seed w4", st[4], 7'b0001011);
        chk("R6", "seed w7", st[7], 7'b0001011);
        tick();
        tick();
        tick();
        chk("R9", "hold w4", st[4], 7'b0001011);
        chk("R9", "hold w3", st[3], 7'b0000011);
    endtask

    // R7, R8: load against enable, zero seed, restart with enable low
    task automatic t_collide();
        do_reset();
        seed7 = 7'b0000110;
        en = 1'b1;
        load = 1'b1;
        tick();
        chk("R7", "load beats shift w4", st[4], 7'b0000110);
        seed7 = 7'b0;
        tick();
        tick();
        chk("R7", "zero seed held w4", st[4], 7'd0);
        chk("R7", "zero seed held w6", st[6], 7'd0);
        chk("R10", "serial at zero", {6'b0, s4}, 7'd0);
        load = 1'b0;
        en = 1'b0;
        tick();
        for (int w = 3; w <= 7; w++) chk("R8", $sformatf("restart w%0d", w), st[w], 7'd1);
        tick();
        chk("R9", "hold after restart w4", st[4], 7'd1);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick();
        t_reset();
        t_order4();
        t_period();
        t_taps();
        t_load_hold();
        t_collide();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule